// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block decides whether a 48-bit destination MAC address falls into a multicast group. The decision uses a 64-bit hash table held as eight 8-bit bytes. On a start strobe the block latches the address and takes a private copy of the table. It then runs a reflected CRC-32, four bits per cycle, over the six address bytes. Six bits of the finished CRC, in reversed order, form a hash. The top three hash bits select a table byte and the bottom three select a bit inside it. The block reports that byte index, the bit number, and whether the selected bit is set.

A host loads the table through a byte-wide write port. The host may write while a lookup runs, because each lookup reads only the copy taken when it started. The result appears together with a one-cycle done strobe at a fixed latency. The result then holds until the next lookup finishes.

Top module: `mc_hash_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy`, `done`, `hit`, `byte_idx` and `bit_num` are all zero.
- R2: The CRC starts at 0xFFFFFFFF. It consumes twelve nibbles in order of rising address bit: byte 0 is `mac_addr[7:0]`, and within each byte the low nibble goes first. Each nibble is XORed into CRC bits [3:0]. Four right-shift steps then follow, and each step XORs in 0xEDB88320 when the bit shifted out was one. The final CRC is used without inversion.
- R3: Hash bit k equals final CRC bit 28-k, for k = 0 to 5. CRC bits 23 to 28 are therefore read in reversed order.
- R4: `byte_idx` equals hash bits [5:2+1] (that is, [5:3]), and `bit_num` equals hash bits [2:0].
- R5: `hit` is one exactly when bit `bit_num` of table byte `byte_idx` is one. Table byte k is the byte last written with `tbl_waddr` = k. All table bytes reset to zero.
- R6: `done` is high for exactly one cycle. It rises on the 12th rising clock edge after the edge that accepts `start`. The new `byte_idx`, `bit_num` and `hit` appear on that same edge and hold until the next `done`.
- R7: A `start` seen while `busy` is high is ignored. It produces no extra `done` and does not change the result of the lookup in flight.
- R8: A table write is allowed on any cycle. A lookup uses the table as it stood just before its accepting edge: a write on that edge, or on any later edge, does not affect that lookup.
- R9: `busy` rises on the accepting edge and falls on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup on `mac_addr`; accepted only when idle |
| mac_addr | input | 48 | Destination address, byte 0 in bits [7:0] |
| tbl_we | input | 1 | Table byte write enable |
| tbl_waddr | input | 3 | Table byte to write |
| tbl_wdata | input | 8 | Table byte value |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle strobe: result updated |
| hit | output | 1 | Selected table bit is set |
| byte_idx | output | 3 | Table byte selected by the hash |
| bit_num | output | 3 | Bit within that byte selected by the hash |

## Verification
Some rules can be checked on every cycle, and the assertions do so. They check that `done` lasts one cycle and arrives exactly twelve busy cycles after acceptance. They check that `busy` brackets each lookup, that a start arriving mid-lookup neither restarts nor extends it, and that the outputs stay frozen between strobes. The hash values themselves can only be shown by the bench's scenarios. It compares each result with a bit-serial CRC model for the all-ones, all-zero and mixed addresses. It also checks the table copy by rewriting the selected byte during a lookup, and covers hits against an empty table and a full table.

// File: rtl/mchash_pkg.sv
package mchash_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int NIB_W      = 4;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int NIBBLES    = ADDR_W / NIB_W;
    localparam int CNT_W      = $clog2(NIBBLES);
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam int HASH_W     = 6;
    localparam int HASH_TOP   = 28;
    localparam int BIT_W      = 3;
    localparam int IDX_W      = HASH_W - BIT_W;
    localparam int TBL_BYTES  = 1 << IDX_W;
    localparam int BYTE_W     = 1 << BIT_W;
    localparam int TBL_BITS   = TBL_BYTES * BYTE_W;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [HASH_W-1:0] hash_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [BIT_W-1:0] bitn;
        logic             hit;
    } mchash_result_t;

    // One right-shifting step of the reflected CRC.
    function automatic crc_t crc_shift(input crc_t c);
        crc_t r;
        r = c >> 1;
        if (c[0]) r = r ^ CRC_POLY;
        return r;
    endfunction

    // Fold one nibble into the low CRC bits, then run four shift steps.
    function automatic crc_t crc_nibble(input crc_t c, input logic [NIB_W-1:0] n);
        crc_t r;
        r = c ^ {{(CRC_W-NIB_W){1'b0}}, n};
        for (int s = 0; s < NIB_W; s++) r = crc_shift(r);
        return r;
    endfunction

    // Reversed pick of the hash field: CRC bit HASH_TOP lands in hash bit 0.
    function automatic hash_t hash_extract(input crc_t c);
        hash_t h;
        for (int k = 0; k < HASH_W; k++) h[k] = c[HASH_TOP-k];
        return h;
    endfunction

endpackage

// File: rtl/mchash_table.sv
module mchash_table
    import mchash_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IDX_W-1:0]    waddr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [TBL_BITS-1:0] tbl_flat
);

    for (genvar g = 0; g < TBL_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (we && (waddr == IDX_W'(g))) begin
                byte_q <= wdata;
            end
        end

        assign tbl_flat[g*BYTE_W +: BYTE_W] = byte_q;
    end

endmodule

// File: rtl/mchash_crc_engine.sv
module mchash_crc_engine
    import mchash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              accept,
    output logic              last,
    output crc_t              crc_next
);

    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIBBLES - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    crc_t              crc_q;
    logic [NIB_W-1:0]  nib;

    assign accept   = start && !busy;
    assign last     = busy && (cnt_q == LAST_NIB);
    assign nib      = addr_q[cnt_q*NIB_W +: NIB_W];
    assign crc_next = crc_nibble(crc_q, nib);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            crc_q  <= '1;
            addr_q <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt_q  <= '0;
            crc_q  <= '1;
            addr_q <= addr;
        end else if (busy) begin
            crc_q <= crc_next;
            cnt_q <= cnt_q + 1'b1;
            if (last) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/mchash_select.sv
module mchash_select
    import mchash_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                last,
    input  crc_t                crc_next,
    input  logic [TBL_BITS-1:0] tbl_flat,
    output mchash_result_t      res
);

    logic [TBL_BITS-1:0] snap_q;
    hash_t               hash;
    mchash_result_t      res_d;

    assign hash       = hash_extract(crc_next);
    assign res_d.idx  = hash[HASH_W-1:BIT_W];
    assign res_d.bitn = hash[BIT_W-1:0];
    assign res_d.hit  = snap_q[hash];

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            res    <= '0;
        end else begin
            if (accept) snap_q <= tbl_flat;
            if (last)   res    <= res_d;
        end
    end

endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
    import mchash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] mac_addr,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_waddr,
    input  logic [BYTE_W-1:0] tbl_wdata,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [BIT_W-1:0]  bit_num
);

    logic [TBL_BITS-1:0] tbl_flat;
    logic                accept;
    logic                last;
    crc_t                crc_next;
    mchash_result_t      res;

    mchash_table u_table (
        .clk      (clk),
        .rst      (rst),
        .we       (tbl_we),
        .waddr    (tbl_waddr),
        .wdata    (tbl_wdata),
        .tbl_flat (tbl_flat)
    );

    mchash_crc_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .addr     (mac_addr),
        .busy     (busy),
        .accept   (accept),
        .last     (last),
        .crc_next (crc_next)
    );

    mchash_select u_select (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .last     (last),
        .crc_next (crc_next),
        .tbl_flat (tbl_flat),
        .res      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= last;
    end

    assign byte_idx = res.idx;
    assign bit_num  = res.bitn;
    assign hit      = res.hit;

endmodule

// File: rtl/mchash_filter_chk.sv
module mchash_filter_chk
    import mchash_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             hit,
    input logic [IDX_W-1:0] byte_idx,
    input logic [BIT_W-1:0] bit_num
);

    localparam int LCNT_W = CNT_W + 1;
    logic [LCNT_W-1:0] busy_cycles;

    always_ff @(posedge clk) begin
        if (rst)                busy_cycles <= '0;
        else if (start && !busy) busy_cycles <= '0;
        else if (busy)          busy_cycles <= busy_cycles + 1'b1;
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cycles == LCNT_W'(NIBBLES)));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(byte_idx) && $stable(bit_num) && $stable(hit)));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

endmodule

bind mc_hash_filter mchash_filter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .hit      (hit),
    .byte_idx (byte_idx),
    .bit_num  (bit_num)
);

// File: tb/mc_hash_filter_bench.sv
module mc_hash_filter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [47:0] mac_addr = '0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_waddr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic        busy, done, hit;
    logic [2:0]  byte_idx, bit_num;

    always #10 clk = ~clk;

    mc_hash_filter u_mc_hash_filter (
        .clk(clk), .rst(rst), .start(start), .mac_addr(mac_addr),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .busy(busy), .done(done), .hit(hit), .byte_idx(byte_idx), .bit_num(bit_num)
    );

    typedef struct packed {
        logic [2:0] idx;
        logic [2:0] bitn;
        logic       hit;
    } exp_t;

    exp_t        exp_q[$];
    logic [7:0]  tb_tbl [8];
    int          n_checks = 0;
    int          n_fail = 0;
    int          done_seen = 0;
    int          cycles = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Bit-serial reflected CRC, one address bit per step, LSB of byte 0 first.
    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [31:0] c;
        logic [5:0]  h;
        logic        fb;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            fb = c[0] ^ a[i];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        for (int k = 0; k < 6; k++) h[k] = c[28-k];
        return h;
    endfunction

    function automatic exp_t predict(input logic [47:0] a);
        exp_t       e;
        logic [5:0] h;
        h      = ref_hash(a);
        e.idx  = h[5:3];
        e.bitn = h[2:0];
        e.hit  = tb_tbl[h[5:3]][h[2:0]];
        return e;
    endfunction

    task automatic write_byte(input logic [2:0] k, input logic [7:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = k; tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
        tb_tbl[k] = v;
    endtask

    // Driver: predict, push, then pulse start for one edge.
    task automatic launch(input logic [47:0] a);
        @(negedge clk);
        exp_q.push_back(predict(a));
        start = 1'b1; mac_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare every result as it is strobed out.
    always @(negedge clk) begin
        if (!rst && done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(byte_idx == e.idx,  "R2/R3/R4 byte_idx", byte_idx, e.idx);
                check(bit_num  == e.bitn, "R2/R3/R4 bit_num",  bit_num,  e.bitn);
                check(hit      == e.hit,  "R5/R8 hit",         hit,      e.hit);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int d0;
        exp_t e;
        logic [2:0] hold_idx, hold_bit;
        logic       hold_hit;

        for (int k = 0; k < 8; k++) tb_tbl[k] = 8'h00;
        repeat (3) @(negedge clk);
        check({busy, done, hit, byte_idx, bit_num} == 9'b0, "R1 outputs in reset",
              {busy, done, hit, byte_idx, bit_num}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, hit, byte_idx, bit_num} == 9'b0, "R1 outputs after reset",
              {busy, done, hit, byte_idx, bit_num}, 0);

        // R5: empty table never hits; R6/R9 latency on the broadcast address.
        launch(48'hFFFF_FFFF_FFFF);
        check(busy == 1'b1, "R9 busy after accept", busy, 1);
        repeat (11) @(negedge clk);
        check(done == 1'b0, "R6 done not early", done, 0);
        check(busy == 1'b1, "R9 busy through last nibble", busy, 1);
        @(negedge clk);
        check(done == 1'b1, "R6 done on 12th edge", done, 1);
        check(busy == 1'b0, "R9 busy falls with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", done, 0);

        launch(48'h0000_0000_0000);
        wait_idle();

        // Load a mixed table; a spread of addresses.
        for (int k = 0; k < 8; k++) write_byte(k[2:0], 8'h96 ^ (k[7:0] * 8'h2B));
        launch(48'h0100_5E00_0001 ^ 48'h0);
        wait_idle();
        launch(48'h0000_0000_0000);
        wait_idle();
        launch(48'hFFFF_FFFF_FFFF);
        wait_idle();
        launch(48'h3333_0000_00FB);
        wait_idle();
        launch(48'hA5C3_1E87_4201);
        wait_idle();

        // R6: outputs hold after the strobe.
        hold_idx = byte_idx; hold_bit = bit_num; hold_hit = hit;
        repeat (5) @(negedge clk);
        check({byte_idx, bit_num, hit} == {hold_idx, hold_bit, hold_hit}, "R6 result holds",
              {byte_idx, bit_num, hit}, {hold_idx, hold_bit, hold_hit});

        // R5: full table always hits.
        for (int k = 0; k < 8; k++) write_byte(k[2:0], 8'hFF);
        launch(48'h0102_0304_0506);
        wait_idle();

        // R7: start while busy is ignored.
        for (int k = 0; k < 8; k++) write_byte(k[2:0], 8'h5A ^ k[7:0]);
        d0 = done_seen;
        launch(48'h0180_C200_0001);
        repeat (4) @(negedge clk);
        start = 1'b1; mac_addr = 48'h1234_5678_9ABC;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check(done_seen - d0 == 1, "R7 one done for one accepted start", done_seen - d0, 1);

        // R8: writing the selected byte mid-lookup is not seen by that lookup.
        e = predict(48'h0100_5E7F_FFFA);
        launch(48'h0100_5E7F_FFFA);
        repeat (3) @(negedge clk);
        write_byte(e.idx, ~tb_tbl[e.idx]);
        wait_idle();
        launch(48'h0100_5E7F_FFFA);
        wait_idle();

        // R8: write on the accepting edge is not seen either.
        e = predict(48'h0100_5E7F_FFFA);
        @(negedge clk);
        exp_q.push_back(e);
        start = 1'b1; mac_addr = 48'h0100_5E7F_FFFA;
        tbl_we = 1'b1; tbl_waddr = e.idx; tbl_wdata = ~tb_tbl[e.idx];
        @(negedge clk);
        start = 1'b0; tbl_we = 1'b0;
        tb_tbl[e.idx] = ~tb_tbl[e.idx];
        wait_idle();

        check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule